// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host read and write a bank of 32-bit registers over a four-wire serial link. The host frames each transaction by pulling chip select low. The first byte it clocks in is a command: the top bit selects read or write, and the remaining seven bits give the starting register address. Data words of 32 bits follow, most significant bit first.

On a write, each complete word becomes one write strobe on the register port. The address then steps by one for the next word in the burst. On a read, the block asks the register bank for the addressed word as soon as the command byte is complete. It shifts that word out on the data-out line, and it fetches the next address at each word boundary. All three host lines pass through synchronizers, so the serial clock must be much slower than the system clock. The host may stall the serial clock for as long as it likes between bits.

The register bank sits outside this block. The block drives a write strobe, address and data. For reads it drives a combinational read request and address, and it takes the read data back in the same cycle.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is held and after it is released, `spi_miso` is 1, `reg_wr_en` is 0 and `reg_rd_req` is 0.
- R2: While `spi_cs_n` is low, `spi_mosi` is sampled on each rising edge of `spi_sck`. The first 8 bits form the command, MSB first: bit 7 = 0 means write, bit 7 = 1 means read, and bits 6..0 give the start address. A read command causes no register write.
- R3: In a write transaction, every 32 bits received after the command produce exactly one single-cycle `reg_wr_en` pulse. That pulse carries the word (first bit received in bit 31) on `reg_wr_data` and the current address on `reg_wr_addr`.
- R4: Successive words of a write burst go to successive addresses, and the address wraps from 127 to 0.
- R5: On a read command, `reg_rd_req` is raised with `reg_rd_addr` equal to the command address when the command byte completes. The returned word is shifted out on `spi_miso`, bit 31 first. Each bit is updated after a falling edge of `spi_sck` and is valid at the following rising edge.
- R6: In a read burst, each completed 32-bit word triggers a request for the next address, wrapping from 127 to 0. The new word is shifted out in the same way.
- R7: If `spi_cs_n` rises before a word is complete, the partial word is discarded and no write occurs. The next transaction starts again with a command byte.
- R8: `spi_miso` is 1 whenever chip select is high, and throughout write transactions.
- R9: A rising edge of `spi_sck` that completes a word counts even if `spi_cs_n` rises at the same moment, so that word is written.
- R10: Pauses of any length in `spi_sck` between bits or bytes do not change the result of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idles high |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 1 when not reading |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 7 | Register write address |
| reg_wr_data | output | 32 | Register write data |
| reg_rd_req | output | 1 | Read request, combinational, valid for one cycle |
| reg_rd_addr | output | 7 | Register read address |
| reg_rd_data | input | 32 | Read data returned by the bank in the same cycle |

## Verification
The delicate coincidence is the final rising edge of a word arriving in the same system cycle as the deassertion of chip select. In that cycle the block must both complete the word and return to idle. The bench provokes this by raising chip select in the same time step as the 32nd rising serial clock edge, so both pass through identical synchronizer chains and land together. It judges the result by expecting exactly one write with the right address and data, and then by reading that register back. A mid-word deassertion is the contrasting case, and it must produce no write.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int SPI_ADDR_W = 7;
    localparam int SPI_DATA_W = 32;

    // Transaction phase: expecting command, receiving write words, sending read words
    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_edge.sv
module spi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cs_n_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic sel_prev
);

    typedef struct packed {
        logic sck;
        logic sel;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d     = edge_q;
        edge_d.sck = sck_s;
        edge_d.sel = ~cs_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '{sck: 1'b1, sel: 1'b0};
        end else begin
            edge_q <= edge_d;
        end
    end

    assign sck_rise = sck_s & ~edge_q.sck;
    assign sck_fall = ~sck_s & edge_q.sck;
    assign sel      = ~cs_n_s;
    assign sel_prev = edge_q.sel;

endmodule

// File: rtl/spi_reg_core.sv
module spi_reg_core
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = SPI_ADDR_W,
    parameter int DATA_W = SPI_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sel,
    input  logic              sel_prev,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              miso,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int              CMD_BITS  = ADDR_W + 1;
    localparam int              CNT_W     = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] tx_sh;
        logic              miso;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } core_t;

    localparam core_t CORE_RST = '{
        phase:   PH_CMD,
        cnt:     '0,
        addr:    '0,
        rx_sh:   '0,
        tx_sh:   '0,
        miso:    1'b1,
        wr_en:   1'b0,
        wr_addr: '0,
        wr_data: '0
    };

    core_t st_d, st_q;
    logic [DATA_W-1:0] sh_in;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        rd_req     = 1'b0;
        rd_addr    = st_q.addr;
        sh_in      = {st_q.rx_sh[DATA_W-2:0], mosi_s};

        // Sampling edge: counts when the transaction was active in the previous cycle
        if (sck_rise && sel_prev) begin
            st_d.rx_sh = sh_in;
            if (st_q.phase == PH_CMD) begin
                if (st_q.cnt == CMD_LAST) begin
                    st_d.cnt  = '0;
                    st_d.addr = sh_in[ADDR_W-1:0];
                    if (sh_in[ADDR_W]) begin
                        st_d.phase = PH_RD;
                        rd_req     = 1'b1;
                        rd_addr    = sh_in[ADDR_W-1:0];
                        st_d.tx_sh = rd_data;
                    end else begin
                        st_d.phase = PH_WR;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == WORD_LAST) begin
                    st_d.cnt  = '0;
                    st_d.addr = st_q.addr + 1'b1;
                    if (st_q.phase == PH_WR) begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_data = sh_in;
                    end else begin
                        rd_req     = 1'b1;
                        rd_addr    = st_q.addr + 1'b1;
                        st_d.tx_sh = rd_data;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        // Launch edge: present the next read bit to the host
        if (sck_fall && sel && st_q.phase == PH_RD) begin
            st_d.miso  = st_q.tx_sh[DATA_W-1];
            st_d.tx_sh = {st_q.tx_sh[DATA_W-2:0], 1'b0};
        end

        // Chip select high: back to idle, partial words dropped
        if (!sel) begin
            st_d.phase = PH_CMD;
            st_d.cnt   = '0;
            st_d.miso  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CORE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso    = st_q.miso;
    assign wr_en   = st_q.wr_en;
    assign wr_addr = st_q.wr_addr;
    assign wr_data = st_q.wr_data;

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W      = SPI_ADDR_W,
    parameter int DATA_W      = SPI_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_req,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data
);

    localparam int LINES = 3;

    logic [LINES-1:0] pins_s;
    logic sck_rise, sck_fall, sel, sel_prev;

    spi_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL({LINES{1'b1}})
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({spi_sck, spi_cs_n, spi_mosi}),
        .sync_out(pins_s)
    );

    spi_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[2]),
        .cs_n_s  (pins_s[1]),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .sel     (sel),
        .sel_prev(sel_prev)
    );

    spi_reg_core #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .sel     (sel),
        .sel_prev(sel_prev),
        .mosi_s  (pins_s[0]),
        .rd_data (reg_rd_data),
        .miso    (spi_miso),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_req  (reg_rd_req),
        .rd_addr (reg_rd_addr)
    );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              sel_prev,
    input logic              miso,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_req
);

    logic              chain_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= 1'b0;
            last_q  <= '0;
        end else if (wr_en) begin
            chain_q <= 1'b1;
            last_q  <= wr_addr;
        end else if (!sel) begin
            chain_q <= 1'b0;
        end
    end

    // R3: a write strobe lasts exactly one cycle
    a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4: consecutive writes inside one burst step the address by one, with wrap
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chain_q) |-> (wr_addr == ADDR_W'(last_q + 1'b1)));

    // R8: with chip select high, the data-out line returns to 1
    a_r8_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> miso);

    // R5: read requests only arise inside an active transaction
    a_r5_rd_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> sel_prev);

    // R2: a write strobe follows an edge seen while the transaction was active
    a_r2_wr_from_txn: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(sel_prev));

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .sel_prev(sel_prev),
    .miso    (spi_miso),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .rd_req  (reg_rd_req)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;

    localparam int AW   = 7;
    localparam int DW   = 32;
    localparam int HALF = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, sck, cs_n, mosi, miso, wr_en, rd_req;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;

    logic [DW-1:0]    bank  [1<<AW];
    logic [DW-1:0]    model [1<<AW];
    logic [AW+DW-1:0] exp_q [$];
    logic [AW+DW-1:0] head;

    int checks = 0, errors = 0, cs_hi = 0;
    bit in_write = 0, done = 0;

    assign rd_data = bank[rd_addr];

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_req(rd_req), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock monitor: write port against expected queue, idle level of miso
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected write at address", 64'(wr_addr), 64'hx);
                end else begin
                    head = exp_q.pop_front();
                    chk({wr_addr, wr_data} == head, "R3", "write address/data",
                        64'({wr_addr, wr_data}), 64'(head));
                end
                bank[wr_addr] = wr_data;
            end
            cs_hi = cs_n ? cs_hi + 1 : 0;
            if (cs_hi >= 6 || in_write)
                chk(miso == 1'b1, "R8", "miso idle level", 64'(miso), 64'd1);
        end
    end

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, input bit cs_with_rise, output logic got);
        sck  = 1'b0;
        mosi = b;
        wait_half();
        got = miso;
        sck = 1'b1;
        if (cs_with_rise) cs_n = 1'b1;
        wait_half();
    endtask

    task automatic shift(input logic [31:0] v, input int n, input bit pause,
                         input bit cs_last, output logic [31:0] got);
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic g;
            bit_xfer(v[i], cs_last && (i == 0), g);
            got = {got[30:0], g};
            if (pause && (i % 8 == 0)) repeat (300) @(negedge clk);
        end
    endtask

    task automatic begin_txn();
        sck  = 1'b1;
        mosi = 1'b1;
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic end_txn(input string req);
        wait_half();
        cs_n     = 1'b1;
        mosi     = 1'b1;
        in_write = 1'b0;
        repeat (4 * HALF) @(negedge clk);
        chk(exp_q.size() == 0, req, "pending expected writes", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic write_burst(input logic [AW-1:0] a, input int n, input logic [31:0] seed);
        logic [31:0] g;
        logic [AW-1:0] p;
        begin_txn();
        in_write = 1'b1;
        shift({24'd0, 1'b0, a}, 8, 1'b0, 1'b0, g);
        p = a;
        for (int k = 0; k < n; k++) begin
            logic [31:0] w;
            w = seed ^ (32'h0101_0101 * k);
            exp_q.push_back({p, w});
            model[p] = w;
            shift(w, 32, 1'b0, 1'b0, g);
            p = p + 1'b1;
        end
        end_txn("R4");
    endtask

    task automatic read_burst(input logic [AW-1:0] a, input int n, input bit pause, input string req);
        logic [31:0] g;
        logic [AW-1:0] p;
        begin_txn();
        shift({24'd0, 1'b1, a}, 8, pause, 1'b0, g);
        p = a;
        for (int k = 0; k < n; k++) begin
            shift(32'hFFFF_FFFF, 32, pause, 1'b0, g);
            chk(g == model[p], req, "read word", 64'(g), 64'(model[p]));
            p = p + 1'b1;
        end
        end_txn("R2");
    endtask

    initial begin
        logic [31:0] g;
        for (int i = 0; i < (1 << AW); i++) begin
            bank[i]  = 32'h5A00_0000 + 32'(i * 7);
            model[i] = 32'h5A00_0000 + 32'(i * 7);
        end
        rst_n = 1'b0; sck = 1'b1; cs_n = 1'b1; mosi = 1'b1;
        repeat (5) @(negedge clk);
        chk(miso == 1'b1,  "R1", "miso in reset",   64'(miso),   64'd1);
        chk(wr_en == 1'b0, "R1", "wr_en in reset",  64'(wr_en),  64'd0);
        chk(rd_req == 1'b0, "R1", "rd_req in reset", 64'(rd_req), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(miso == 1'b1 && !wr_en, "R1", "idle after reset", 64'({miso, wr_en}), 64'h2);

        // R2 R3: single word write, then read it back
        write_burst(7'd5, 1, 32'hDEAD_BEEF);
        read_burst(7'd5, 1, 1'b0, "R5");

        // R4: burst across the top of the address space
        write_burst(7'd126, 3, 32'h1234_5678);
        // R6 R10: read burst wrapping, with long clock pauses
        read_burst(7'd127, 2, 1'b1, "R6");
        read_burst(7'd0, 1, 1'b1, "R10");

        // R7: chip select rises mid-word, nothing written
        begin_txn();
        in_write = 1'b1;
        shift({24'd0, 8'h0A}, 8, 1'b0, 1'b0, g);
        shift(32'hCAFE_F00D, 20, 1'b0, 1'b0, g);
        end_txn("R7");
        read_burst(7'd10, 1, 1'b0, "R7");

        // R9: chip select rises together with the last sampling edge
        begin_txn();
        in_write = 1'b1;
        shift({24'd0, 8'h14}, 8, 1'b0, 1'b0, g);
        exp_q.push_back({7'd20, 32'hA5C3_0F96});
        model[20] = 32'hA5C3_0F96;
        shift(32'hA5C3_0F96, 32, 1'b0, 1'b1, g);
        end_txn("R9");
        read_burst(7'd20, 1, 1'b0, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule